// File: doc/BRIEF.md
# DSP Subsystem Power-Down Sequencer

This block takes a processor subsystem from its running state to fully powered down after one shutdown request. The first step asserts the core resets and leaves the subsystem itself out of reset, so its control registers stay reachable. A timed wait follows so the core reset can propagate. The block then clamps the I/O, stops the core clock, opens every memory footswitch and resets the subsystem. The last step gates the subsystem bus clock and raises a one-cycle completion pulse.

Every control output comes straight from a register. The reset controls are driven as one 5-bit image, so each encoding can be observed at the port. The wait length is set by a cycles-per-microsecond parameter and a wait length in microseconds. Once the sequence has finished, the outputs stay in the off state until a synchronous reset brings the block back to the running state.

Top module: `dsp_pwrdn_seq`

## Requirements
- R1: After synchronous reset, `rst_ctl` is 0x00 (bit 0 is the subsystem reset, bits 4..1 are the core resets, and 1 means asserted). In the same state `clamp_io` is 0, `core_clk_en` is 1, every bit of `mem_fs_en` is 1, `bus_clk_en` is 1 and `done` is 0.
- R2: A `start` pulse seen in the running state sets `rst_ctl` to 0x1E on the next clock edge, with all other outputs unchanged.
- R3: `clamp_io` rises exactly WAIT_US*CYC_PER_US clock edges after `rst_ctl` first shows 0x1E, and `core_clk_en` is still 1 at that point.
- R4: `core_clk_en` falls one clock edge after `clamp_io` rises.
- R5: All bits of `mem_fs_en` fall together, one clock edge after `core_clk_en` falls.
- R6: `rst_ctl` becomes 0x1F, with the subsystem reset bit set, one clock edge after the footswitches open.
- R7: `bus_clk_en` falls one clock edge after `rst_ctl` becomes 0x1F. `done` is 1 in that same cycle only.
- R8: A `start` pulse that arrives while the sequence is in progress has no effect on any output or on the step timing.
- R9: After the sequence completes, the outputs hold `rst_ctl`=0x1F, `clamp_io`=1, both clock enables at 0 and footswitches at 0. Any further `start` is ignored until reset.
- R10: While the block is running and `start` is low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; returns the block to the running state |
| start | input | 1 | Shutdown request pulse |
| rst_ctl | output | 5 | Reset-control image: bit 0 is the subsystem reset, bits 4..1 are the core resets |
| clamp_io | output | 1 | I/O clamp, 1 = clamped |
| core_clk_en | output | 1 | Core clock enable |
| mem_fs_en | output | NUM_FS | Memory footswitch enables, 1 = powered |
| bus_clk_en | output | 1 | Subsystem bus clock enable |
| done | output | 1 | One-cycle pulse when the last step completes |

## Verification
The hardest case to reach from the ports is a second request that lands inside the sequence. It has to arrive both during the propagation wait and during the one-cycle gating steps, because a fault there would restart the wait or skip a step. The bench pulses `start` a few cycles into the wait and again during the gating steps, and in another run holds `start` high for several cycles. It checks every cycle against the single expected timeline that was queued for the first request. A request made after completion is checked the same way, against a queue of unchanging off-state snapshots.

// File: rtl/dsp_pwrdn_pkg.sv
package dsp_pwrdn_pkg;

  localparam int RST_W = 5;
  localparam logic [RST_W-1:0] RST_RUNNING   = 5'h00;
  localparam logic [RST_W-1:0] RST_CORE_HOLD = 5'h1E;
  localparam int RST_SS_BIT = 0;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_WAIT,
    ST_CLAMP,
    ST_CLKOFF,
    ST_FSOFF,
    ST_SSRST,
    ST_OFF
  } seq_state_t;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_CORE_RST,
    EV_CLAMP,
    EV_CLK_OFF,
    EV_FS_OFF,
    EV_SS_RST,
    EV_BUS_OFF
  } seq_event_t;

endpackage

// File: rtl/dsp_pwrdn_timer.sv
module dsp_pwrdn_timer #(
  parameter int WAIT_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC + 1) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYC - 1);

  logic [CNT_W-1:0] cnt;

  // The count is loaded on the edge that asserts the core reset.
  // It expires on the WAIT_CYC-th edge after that one.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= LOAD_VAL;
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);

endmodule

// File: rtl/dsp_pwrdn_fsm.sv
module dsp_pwrdn_fsm
  import dsp_pwrdn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       wait_done,
  output logic       wait_load,
  output logic       wait_run,
  output seq_event_t evt
);

  seq_state_t state, state_nx;

  always_comb begin
    state_nx  = state;
    evt       = EV_NONE;
    wait_load = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (start) begin
          state_nx  = ST_WAIT;
          evt       = EV_CORE_RST;
          wait_load = 1'b1;
        end
      end
      ST_WAIT: begin
        if (wait_done) begin
          state_nx = ST_CLAMP;
          evt      = EV_CLAMP;
        end
      end
      ST_CLAMP: begin
        state_nx = ST_CLKOFF;
        evt      = EV_CLK_OFF;
      end
      ST_CLKOFF: begin
        state_nx = ST_FSOFF;
        evt      = EV_FS_OFF;
      end
      ST_FSOFF: begin
        state_nx = ST_SSRST;
        evt      = EV_SS_RST;
      end
      ST_SSRST: begin
        state_nx = ST_OFF;
        evt      = EV_BUS_OFF;
      end
      ST_OFF: begin
        state_nx = ST_OFF;
      end
      default: begin
        state_nx = ST_RUN;
      end
    endcase
  end

  assign wait_run = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RUN;
    end else begin
      state <= state_nx;
    end
  end

endmodule

// File: rtl/dsp_pwrdn_regs.sv
module dsp_pwrdn_regs
  import dsp_pwrdn_pkg::*;
#(
  parameter int NUM_FS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_event_t        evt,
  output logic [RST_W-1:0]  rst_ctl,
  output logic              clamp_io,
  output logic              core_clk_en,
  output logic [NUM_FS-1:0] mem_fs_en,
  output logic              bus_clk_en,
  output logic              done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_ctl <= RST_RUNNING;
    end else if (evt == EV_CORE_RST) begin
      rst_ctl <= RST_CORE_HOLD;
    end else if (evt == EV_SS_RST) begin
      rst_ctl[RST_SS_BIT] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clamp_io    <= 1'b0;
      core_clk_en <= 1'b1;
      bus_clk_en  <= 1'b1;
      done        <= 1'b0;
    end else begin
      done <= (evt == EV_BUS_OFF);
      if (evt == EV_CLAMP)   clamp_io    <= 1'b1;
      if (evt == EV_CLK_OFF) core_clk_en <= 1'b0;
      if (evt == EV_BUS_OFF) bus_clk_en  <= 1'b0;
    end
  end

  // One enable register per memory bank footswitch.
  for (genvar g = 0; g < NUM_FS; g++) begin : g_fs
    always_ff @(posedge clk) begin
      if (rst) begin
        mem_fs_en[g] <= 1'b1;
      end else if (evt == EV_FS_OFF) begin
        mem_fs_en[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dsp_pwrdn_seq.sv
module dsp_pwrdn_seq
  import dsp_pwrdn_pkg::*;
#(
  parameter int CYC_PER_US = 4,
  parameter int WAIT_US    = 2,
  parameter int NUM_FS     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [4:0]        rst_ctl,
  output logic              clamp_io,
  output logic              core_clk_en,
  output logic [NUM_FS-1:0] mem_fs_en,
  output logic              bus_clk_en,
  output logic              done
);

  localparam int WAIT_CYC = (CYC_PER_US * WAIT_US > 0) ? CYC_PER_US * WAIT_US : 1;

  logic       wait_load;
  logic       wait_run;
  logic       wait_done;
  seq_event_t evt;

  dsp_pwrdn_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (wait_load),
    .run     (wait_run),
    .expired (wait_done)
  );

  dsp_pwrdn_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .wait_done (wait_done),
    .wait_load (wait_load),
    .wait_run  (wait_run),
    .evt       (evt)
  );

  dsp_pwrdn_regs #(.NUM_FS(NUM_FS)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .evt         (evt),
    .rst_ctl     (rst_ctl),
    .clamp_io    (clamp_io),
    .core_clk_en (core_clk_en),
    .mem_fs_en   (mem_fs_en),
    .bus_clk_en  (bus_clk_en),
    .done        (done)
  );

endmodule

// File: rtl/dsp_pwrdn_seq_chk.sv
module dsp_pwrdn_seq_chk #(
  parameter int CYC_PER_US = 4,
  parameter int WAIT_US    = 2,
  parameter int NUM_FS     = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        rst_ctl,
  input logic              clamp_io,
  input logic              core_clk_en,
  input logic [NUM_FS-1:0] mem_fs_en,
  input logic              bus_clk_en,
  input logic              done
);

  localparam int WAIT_CYC = (CYC_PER_US * WAIT_US > 0) ? CYC_PER_US * WAIT_US : 1;

  logic [31:0] hold_cnt;
  logic        fs_any;

  assign fs_any = |mem_fs_en;

  // Counts the edges seen with the core held in reset and the clamp still open.
  always_ff @(posedge clk) begin
    if (rst || rst_ctl == 5'h00) begin
      hold_cnt <= '0;
    end else if (rst_ctl == 5'h1E && !clamp_io) begin
      hold_cnt <= hold_cnt + 1;
    end
  end

  AST_CLAMP_WAIT: assert property (@(posedge clk) disable iff (rst)
    $rose(clamp_io) |-> (hold_cnt == WAIT_CYC && rst_ctl == 5'h1E && core_clk_en)); // R3

  AST_CLK_AFTER_CLAMP: assert property (@(posedge clk) disable iff (rst)
    $fell(core_clk_en) |-> (clamp_io && $past(clamp_io) && fs_any)); // R4

  AST_FS_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    (mem_fs_en != {NUM_FS{1'b1}}) |-> (mem_fs_en == '0 && !core_clk_en)); // R5

  AST_SS_AFTER_FS: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_ctl[0]) |-> (!fs_any && $past(!fs_any) && rst_ctl == 5'h1F)); // R6

  AST_BUS_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_clk_en) |-> (rst_ctl == 5'h1F && done)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bus_clk_en |=> (!bus_clk_en && rst_ctl == 5'h1F && clamp_io)); // R9

endmodule

bind dsp_pwrdn_seq dsp_pwrdn_seq_chk #(
  .CYC_PER_US (CYC_PER_US),
  .WAIT_US    (WAIT_US),
  .NUM_FS     (NUM_FS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rst_ctl     (rst_ctl),
  .clamp_io    (clamp_io),
  .core_clk_en (core_clk_en),
  .mem_fs_en   (mem_fs_en),
  .bus_clk_en  (bus_clk_en),
  .done        (done)
);

// File: tb/sim_dsp_pwrdn_seq.sv
`timescale 1ns/1ps
module sim_dsp_pwrdn_seq;

  localparam int CYC_PER_US = 4;
  localparam int WAIT_US    = 2;
  localparam int NUM_FS     = 7;
  localparam int WAIT_CYC   = CYC_PER_US * WAIT_US;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [4:0]        rst_ctl;
  logic              clamp_io;
  logic              core_clk_en;
  logic [NUM_FS-1:0] mem_fs_en;
  logic              bus_clk_en;
  logic              done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct packed {
    logic [4:0]        r;
    logic              c;
    logic              k;
    logic [NUM_FS-1:0] f;
    logic              b;
    logic              d;
  } snap_t;

  snap_t exp_q[$];

  always #2.5 clk = ~clk;

  dsp_pwrdn_seq #(.CYC_PER_US(CYC_PER_US), .WAIT_US(WAIT_US), .NUM_FS(NUM_FS)) u0 (
    .clk(clk), .rst(rst), .start(start), .rst_ctl(rst_ctl), .clamp_io(clamp_io),
    .core_clk_en(core_clk_en), .mem_fs_en(mem_fs_en), .bus_clk_en(bus_clk_en), .done(done)
  );

  function automatic snap_t mk(logic [4:0] r, logic c, logic k, logic f, logic b, logic d);
    snap_t s;
    s.r = r; s.c = c; s.k = k; s.f = {NUM_FS{f}}; s.b = b; s.d = d;
    return s;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
    end
  endtask

  // Monitor: compares one queued snapshot on every falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        snap_t e;
        e = exp_q.pop_front();
        chk("R2/R6", "rst_ctl",     32'(rst_ctl),     32'(e.r));
        chk("R3",    "clamp_io",    32'(clamp_io),    32'(e.c));
        chk("R4",    "core_clk_en", 32'(core_clk_en), 32'(e.k));
        chk("R5",    "mem_fs_en",   32'(mem_fs_en),   32'(e.f));
        chk("R7",    "bus_clk_en",  32'(bus_clk_en),  32'(e.b));
        chk("R7",    "done",        32'(done),        32'(e.d));
      end
    end
  end

  // Driver: issues a request and queues the expected per-cycle timeline.
  task automatic request(bit expect_run, int hold);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1;
    if (expect_run) begin
      for (int i = 1; i <= WAIT_CYC; i++) exp_q.push_back(mk(5'h1E, 0, 1, 1, 1, 0)); // R2 R3
      exp_q.push_back(mk(5'h1E, 1, 1, 1, 1, 0)); // R3
      exp_q.push_back(mk(5'h1E, 1, 0, 1, 1, 0)); // R4
      exp_q.push_back(mk(5'h1E, 1, 0, 0, 1, 0)); // R5
      exp_q.push_back(mk(5'h1F, 1, 0, 0, 1, 0)); // R6
      exp_q.push_back(mk(5'h1F, 1, 0, 0, 0, 1)); // R7
      for (int i = 0; i < 3; i++) exp_q.push_back(mk(5'h1F, 1, 0, 0, 0, 0)); // R9
    end else begin
      for (int i = 0; i < 5; i++) exp_q.push_back(mk(5'h1F, 1, 0, 0, 0, 0)); // R9
    end
    for (int i = 1; i < hold; i++) @(negedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_running(string tag);
    chk(tag, "rst_ctl",     32'(rst_ctl),     32'h00);
    chk(tag, "clamp_io",    32'(clamp_io),    32'h0);
    chk(tag, "core_clk_en", 32'(core_clk_en), 32'h1);
    chk(tag, "mem_fs_en",   32'(mem_fs_en),   32'({NUM_FS{1'b1}}));
    chk(tag, "bus_clk_en",  32'(bus_clk_en),  32'h1);
    chk(tag, "done",        32'(done),        32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_running("R1");

    // R10: idle without start, nothing moves
    @(posedge clk); #1;
    for (int i = 0; i < 6; i++) exp_q.push_back(mk(5'h00, 0, 1, 1, 1, 0));
    drain();

    // R2..R7 with extra requests inside the sequence (R8)
    fork
      request(1, 1);
      begin
        repeat (4) @(negedge clk);
        pulse_start();                       // R8: during the wait
        repeat (WAIT_CYC - 2) @(negedge clk);
        pulse_start();                       // R8: during the gating steps
      end
    join
    drain();

    // R9: request after completion is ignored
    request(0, 1);
    drain();

    // R1 again after a reset from the off state, then a held request (R8)
    do_reset();
    check_running("R1");
    request(1, 4);
    drain();
    request(0, 3);                           // R9
    drain();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule